// File: doc/BRIEF.md
# Strapped-Default GPIO Port Controller

This block owns sixteen general-purpose pins, arranged as two 8-bit ports (port 0 and port 1), and the small register set that controls them. A parallel register bus writes and reads the per-port output, direction and LED-mode registers, a global control register and one dimming register per pin. From these the block computes, for every pin, a drive value and a drive enable for the pad. It also computes an LED enable and an 8-bit dimming code that go to an external current DAC. Pin levels come back through a two-flop synchronizer and can be read from the input-state registers.

At reset the output registers do not clear to a fixed value. They load a pattern chosen by two strap inputs, so a board can make its pins come up high or released before software runs. Port 1 always drives push-pull. Port 0 drives open-drain until software selects push-pull in the global control register.

Top module: `gpx_port_ctl`

## Requirements
- R1: While reset is active the direction registers (0x08 port 0, 0x09 port 1) load 00h, so every pin is an output. The LED-mode registers (0x0C, 0x0D) load FFh, so every pin is GPIO. The control register (0x10) and all dimming registers load 00h. After reset led_en is 0, dim_code is all zero and dim_range is 0.
- R2: While reset is active each output register (0x04 port 0, 0x05 port 1) loads a pattern set by the straps. Bits [3:0] copy strap[0] and bits [7:4] copy strap[1].
- R3: When a direction bit is 1, that pin is an input and its pin_oe is 0. When the bit is 0, the pin is an output.
- R4: Port 1 output pins (pin_out/pin_oe bits 15:8) are push-pull: pin_oe is 1 and pin_out equals the output-register bit.
- R5: When control bit 4 is 0, port 0 output pins (bits 7:0) are open-drain. An output bit of 0 gives pin_oe=1 and pin_out=0, and an output bit of 1 gives pin_oe=0. When control bit 4 is 1, port 0 behaves as push-pull, like R4.
- R6: Reading an output register returns the stored value, not the level on the pins.
- R7: The input-state registers (0x00 port 0, 0x01 port 1) return pin_in through two synchronizer flops. A change driven before clock edge k can be read after edge k+1, and the old value is still read after edge k. Writes to these addresses change nothing.
- R8: An LED-mode bit of 0 puts the pin in LED mode: led_en is 1, pin_oe is 0, and dim_code[8*i+7:8*i] shows the dimming register of pin i. A pin in GPIO mode shows dim_code 0 for its slot.
- R9: Control register bits [1:0] drive dim_range (0 full, 1 three quarters, 2 half, 3 one quarter). Only bits 4, 1 and 0 are stored, and every other control bit reads 0.
- R10: Dimming register of pin i sits at 0x20+i and reads back what was written. Pins 0-7 are port 0 and pins 8-15 are port 1. Reads of unmapped addresses return 00h, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap | input | 2 | Reset-default select straps |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Pad drive value |
| pin_oe | output | 16 | Pad drive enable |
| led_en | output | 16 | Pin is in LED mode |
| dim_code | output | 128 | Per-pin dimming code, 8 bits per pin |
| dim_range | output | 2 | Dimming range select |

## Verification
The bench resets the block under all four strap values and checks both the stored output registers and the resulting pad drive. A design that applied the straps to the wrong half-port, or that drove a released open-drain pin high, fails these checks. It reads an input-state register one and two edges after a pin change to pin down the synchronizer latency, so a missing flop or an extra flop shows up. It also drives pins against the output register, which catches a design that reads the pins back instead of the stored value. Other directed cases check that an LED-mode pin drops its GPIO driver and exposes only its own dimming code, that the push-pull bit takes port 0 out of open-drain, and that writes to the input and unmapped addresses leave every register unchanged.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  // register bus width, also the width of one port
  localparam int DW = 8;

  localparam logic [7:0] A_IN_BASE   = 8'h00;
  localparam logic [7:0] A_OUT_BASE  = 8'h04;
  localparam logic [7:0] A_DIR_BASE  = 8'h08;
  localparam logic [7:0] A_MODE_BASE = 8'h0C;
  localparam logic [7:0] A_CTL       = 8'h10;
  localparam logic [7:0] A_DIM_BASE  = 8'h20;

  localparam int CTL_PP_BIT = 4;

  // reset pattern of one port: lower half follows strap[0], upper half strap[1]
  function automatic logic [DW-1:0] strap_fill(input logic [1:0] strap);
    logic [DW-1:0] v;
    for (int b = 0; b < DW; b++) v[b] = (b < DW/2) ? strap[0] : strap[1];
    return v;
  endfunction

  // pad drive of one pin: returns {oe, value}
  function automatic logic [1:0] pad_drive(input logic out_bit, input logic is_input,
                                           input logic is_led, input logic open_drain);
    if (is_input || is_led) return 2'b00;
    if (open_drain)         return {~out_bit, 1'b0};
    return {1'b1, out_bit};
  endfunction
endpackage

// File: rtl/gpx_insync.sv
module gpx_insync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk) begin
    s1_q <= din;
    s2_q <= s1_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assign dout = s2_q;

  // R7
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter  int NPORT = 2,
  localparam int NPIN  = NPORT * DW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               strap,
  input  logic                     wr,
  input  logic [7:0]               addr,
  input  logic [DW-1:0]            wdata,
  input  logic [NPIN-1:0]          in_sync,
  output logic [DW-1:0]            rdata,
  output logic [NPIN-1:0]          out_q,
  output logic [NPIN-1:0]          dir_q,
  output logic [NPIN-1:0]          mode_q,
  output logic                     ctl_pp,
  output logic [1:0]               ctl_range,
  output logic [NPIN-1:0][DW-1:0]  dim_q
);
  logic wr_in_hit;
  logic wr_ctl_hit;

  assign wr_in_hit  = wr && ((addr - A_IN_BASE) < 8'(NPORT));
  assign wr_ctl_hit = wr && (addr == A_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++) out_q[p*DW +: DW] <= strap_fill(strap);
      dir_q     <= '0;
      mode_q    <= '1;
      ctl_pp    <= 1'b0;
      ctl_range <= 2'd0;
      dim_q     <= '0;
    end else if (wr) begin
      for (int p = 0; p < NPORT; p++) begin
        if (addr == A_OUT_BASE  + 8'(p)) out_q [p*DW +: DW] <= wdata;
        if (addr == A_DIR_BASE  + 8'(p)) dir_q [p*DW +: DW] <= wdata;
        if (addr == A_MODE_BASE + 8'(p)) mode_q[p*DW +: DW] <= wdata;
      end
      if (wr_ctl_hit) begin
        ctl_pp    <= wdata[CTL_PP_BIT];
        ctl_range <= wdata[1:0];
      end
      for (int i = 0; i < NPIN; i++)
        if (addr == A_DIM_BASE + 8'(i)) dim_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (addr == A_IN_BASE   + 8'(p)) rdata = in_sync[p*DW +: DW];
      if (addr == A_OUT_BASE  + 8'(p)) rdata = out_q  [p*DW +: DW];
      if (addr == A_DIR_BASE  + 8'(p)) rdata = dir_q  [p*DW +: DW];
      if (addr == A_MODE_BASE + 8'(p)) rdata = mode_q [p*DW +: DW];
    end
    if (addr == A_CTL) begin
      rdata[CTL_PP_BIT] = ctl_pp;
      rdata[1:0]        = ctl_range;
    end
    for (int i = 0; i < NPIN; i++)
      if (addr == A_DIM_BASE + 8'(i)) rdata = dim_q[i];
  end

  // R2
  strap_load_chk: assert property (@(posedge clk)
    (!rst_n) |=> (out_q == {NPORT{strap_fill($past(strap))}}));

  // R7
  in_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in_hit |=> ($stable(out_q) && $stable(dir_q) && $stable(mode_q) &&
                   $stable(ctl_pp) && $stable(ctl_range) && $stable(dim_q)));

  // R9
  ctl_range_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl_hit |=> (ctl_range == $past(wdata[1:0])));
endmodule

// File: rtl/gpx_pad_ctl.sv
module gpx_pad_ctl
  import gpx_pkg::*;
#(
  parameter  int NPORT = 2,
  localparam int NPIN  = NPORT * DW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPIN-1:0]          out_q,
  input  logic [NPIN-1:0]          dir_q,
  input  logic [NPIN-1:0]          mode_q,
  input  logic                     ctl_pp,
  input  logic [NPIN-1:0][DW-1:0]  dim_q,
  output logic [NPIN-1:0]          pin_out,
  output logic [NPIN-1:0]          pin_oe,
  output logic [NPIN-1:0]          led_en,
  output logic [NPIN*DW-1:0]       dim_code
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    // only port 0 can run open-drain
    localparam bit OD_CAPABLE = (i < DW);
    logic [1:0] drv;
    assign drv    = pad_drive(out_q[i], dir_q[i], ~mode_q[i], OD_CAPABLE && !ctl_pp);
    assign pin_oe[i]  = drv[1];
    assign pin_out[i] = drv[0];
    assign led_en[i]  = ~mode_q[i];
    assign dim_code[i*DW +: DW] = mode_q[i] ? '0 : dim_q[i];
  end

  // R8
  led_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((led_en & pin_oe) == '0));

  // R3
  dir_in_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & pin_oe) == '0));

  // R5
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_pp) |-> (pin_out[DW-1:0] == '0));
endmodule

// File: rtl/gpx_port_ctl.sv
module gpx_port_ctl
  import gpx_pkg::*;
#(
  parameter  int NPORT = 2,
  localparam int NPIN  = NPORT * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           strap,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [NPIN-1:0]      pin_in,
  output logic [NPIN-1:0]      pin_out,
  output logic [NPIN-1:0]      pin_oe,
  output logic [NPIN-1:0]      led_en,
  output logic [NPIN*DW-1:0]   dim_code,
  output logic [1:0]           dim_range
);
  logic [NPIN-1:0]         in_sync;
  logic [NPIN-1:0]         out_q, dir_q, mode_q;
  logic                    ctl_pp;
  logic [1:0]              ctl_range;
  logic [NPIN-1:0][DW-1:0] dim_q;

  gpx_insync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(in_sync)
  );

  gpx_regfile #(.NPORT(NPORT)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap(strap),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .in_sync(in_sync),
    .rdata(reg_rdata), .out_q(out_q), .dir_q(dir_q), .mode_q(mode_q),
    .ctl_pp(ctl_pp), .ctl_range(ctl_range), .dim_q(dim_q)
  );

  gpx_pad_ctl #(.NPORT(NPORT)) u_pads (
    .clk(clk), .rst_n(rst_n),
    .out_q(out_q), .dir_q(dir_q), .mode_q(mode_q), .ctl_pp(ctl_pp), .dim_q(dim_q),
    .pin_out(pin_out), .pin_oe(pin_oe), .led_en(led_en), .dim_code(dim_code)
  );

  assign dim_range = ctl_range;
endmodule

// File: tb/gpx_port_ctl_tb_top.sv
module gpx_port_ctl_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   strap = 2'b00;
  logic         reg_wr = 1'b0;
  logic [7:0]   reg_addr = 8'h00;
  logic [7:0]   reg_wdata = 8'h00;
  logic [7:0]   reg_rdata;
  logic [15:0]  pin_in = 16'h0000;
  logic [15:0]  pin_out, pin_oe, led_en;
  logic [127:0] dim_code;
  logic [1:0]   dim_range;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpx_port_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .strap(strap), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .led_en(led_en), .dim_code(dim_code), .dim_range(dim_range)
  );

  // {address, write data, expected read-back}; pins held at 16'h3C96
  localparam logic [23:0] VEC [13] = '{
    24'h04A5A5, 24'h053C3C, 24'h080F0F, 24'h098181, 24'h0C7E7E,
    24'h0DFFFF, 24'h10FF13, 24'h005596, 24'h01AA3C, 24'h201212,
    24'h2FEEEE, 24'h077700, 24'h3F9900
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s, input logic [15:0] pins);
    @(negedge clk);
    rst_n = 1'b0; strap = s; pin_in = pins;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] fill(input logic [1:0] s);
    return {{4{s[1]}}, {4{s[0]}}};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    logic [7:0] e;

    // table walk: write then read back
    do_reset(2'b00, 16'h3C96);
    for (int k = 0; k < 13; k++) begin
      wr(VEC[k][23:16], VEC[k][15:8]);
      rd(VEC[k][23:16], r);
      chk($sformatf("R10/R7/R9 vec%0d addr %h", k, VEC[k][23:16]), {24'h0, r}, {24'h0, VEC[k][7:0]});
    end

    // R1 reset state, R2 strap 00, R4/R5 drive
    do_reset(2'b00, 16'h0000);
    rd(8'h08, r); chk("R1 dir p0", {24'h0, r}, 32'h00);
    rd(8'h09, r); chk("R1 dir p1", {24'h0, r}, 32'h00);
    rd(8'h0C, r); chk("R1 mode p0", {24'h0, r}, 32'hFF);
    rd(8'h0D, r); chk("R1 mode p1", {24'h0, r}, 32'hFF);
    rd(8'h10, r); chk("R1 ctl", {24'h0, r}, 32'h00);
    rd(8'h25, r); chk("R1 dim", {24'h0, r}, 32'h00);
    chk("R1 led_en", {16'h0, led_en}, 32'h0);
    chk("R1 dim_code", {31'h0, |dim_code}, 32'h0);
    chk("R1 dim_range", {30'h0, dim_range}, 32'h0);

    // R2 strap patterns, with R4/R5 pad drive
    for (int s = 0; s < 4; s++) begin
      e = fill(2'(s));
      do_reset(2'(s), 16'h0000);
      rd(8'h04, r); chk($sformatf("R2 out p0 strap%0d", s), {24'h0, r}, {24'h0, e});
      rd(8'h05, r); chk($sformatf("R2 out p1 strap%0d", s), {24'h0, r}, {24'h0, e});
      chk($sformatf("R4 p1 oe strap%0d", s), {24'h0, pin_oe[15:8]}, 32'hFF);
      chk($sformatf("R4 p1 value strap%0d", s), {24'h0, pin_out[15:8]}, {24'h0, e});
      chk($sformatf("R5 p0 oe strap%0d", s), {24'h0, pin_oe[7:0]}, {24'h0, ~e});
      chk($sformatf("R5 p0 value strap%0d", s), {24'h0, pin_out[7:0]}, 32'h0);
    end

    // R6: output register read ignores pin level (strap 11, pins all low)
    rd(8'h05, r); chk("R6 out p1 stored", {24'h0, r}, 32'hFF);
    rd(8'h01, r); chk("R6 in p1 pins", {24'h0, r}, 32'h00);

    // R5 push-pull on port 0
    wr(8'h10, 8'h10);
    chk("R5 pp oe", {16'h0, pin_oe}, 32'hFFFF);
    wr(8'h04, 8'h3C);
    chk("R5 pp value", {24'h0, pin_out[7:0]}, 32'h3C);
    wr(8'h10, 8'h00);
    chk("R5 od again oe", {24'h0, pin_oe[7:0]}, 32'hC3);

    // R3 direction
    wr(8'h09, 8'hF0);
    chk("R3 p1 oe", {24'h0, pin_oe[15:8]}, 32'h0F);
    wr(8'h08, 8'h01);
    wr(8'h04, 8'h00);
    chk("R3 p0 oe", {24'h0, pin_oe[7:0]}, 32'hFE);

    // R8 LED mode
    wr(8'h09, 8'h00);
    wr(8'h0D, 8'hFE);
    wr(8'h28, 8'h80);
    wr(8'h29, 8'h11);
    wr(8'h08, 8'h00);
    wr(8'h0C, 8'hFE);
    wr(8'h20, 8'hFF);
    chk("R8 led_en", {16'h0, led_en}, 32'h0101);
    chk("R8 oe", {16'h0, pin_oe}, 32'hFEFE);
    chk("R8 code pin8", {24'h0, dim_code[71:64]}, 32'h80);
    chk("R8 code pin9 gpio", {24'h0, dim_code[79:72]}, 32'h00);
    chk("R8 code pin0", {24'h0, dim_code[7:0]}, 32'hFF);

    // R9 range and reserved bits
    wr(8'h10, 8'hE3);
    chk("R9 dim_range", {30'h0, dim_range}, 32'h3);
    rd(8'h10, r); chk("R9 ctl read", {24'h0, r}, 32'h03);
    wr(8'h10, 8'h01);
    chk("R9 dim_range 1", {30'h0, dim_range}, 32'h1);

    // R10 unmapped write changes nothing
    wr(8'h06, 8'h5A);
    rd(8'h04, r); chk("R10 out p0 kept", {24'h0, r}, 32'h00);
    rd(8'h06, r); chk("R10 unmapped read", {24'h0, r}, 32'h00);

    // R7 synchronizer latency
    @(negedge clk);
    pin_in = 16'h0096;
    repeat (3) @(posedge clk);
    @(negedge clk);
    pin_in = 16'h005A;
    @(posedge clk);
    rd(8'h00, r); chk("R7 after one edge", {24'h0, r}, 32'h96);
    @(posedge clk);
    rd(8'h00, r); chk("R7 after two edges", {24'h0, r}, 32'h5A);
    wr(8'h00, 8'hFF);
    rd(8'h00, r); chk("R7 write ignored", {24'h0, r}, 32'h5A);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule